// File: doc/BRIEF.md
# Block-Merging Store Write Buffer

This block sits between a write-through first-level data cache that does not allocate on a write miss and the second-level cache. Every store the processor issues arrives here, whether or not it hit in the first level. The buffer keeps a small number of entries. Each entry holds one whole cache block together with a byte-valid mask. A store whose block address is already buffered is folded into that entry. A store to a new block claims a free entry. When no entry is free and the store cannot merge, the processor is held by a stall signal.

Entries leave in the order they were claimed, through a drain port with a valid/ready handshake. An entry whose mask covers the whole block is flagged as a full-block write. Any other entry is a partial write carrying its mask. Because sequential stores to one block coalesce, a run of stores that covers a block reaches the second level as a single full-block write.

Top module: `wbuf_merge`

## Requirements
- R1: While reset is asserted, and right after it is released, `dr_valid` is 0 and `st_stall` is 0.
- R2: A store to a block with no buffered entry claims a new entry. When that entry drains, `dr_addr` is the store address with its low 5 bits cleared. Bits `st_addr[4:3]` select the 8-byte word k of the 32-byte block, and `st_be` bit j marks block byte 8k+j. Block byte i appears at `dr_data[8i+7:8i]` and sets `dr_mask[i]`.
- R3: A store whose block matches a buffered entry that is not draining merges into that entry. The mask becomes the union of both masks, and bytes written later replace the earlier bytes.
- R4: `dr_full` is 1 exactly when all 32 bits of `dr_mask` are set.
- R5: Entries drain in the order they were claimed. After the last entry drains, `dr_valid` is 0.
- R6: At most 4 entries are held. With 4 entries held and no drain taking place, a store to a fifth block sees `st_stall` = 1 and is not taken.
- R7: `st_stall` is 1 only when a store is offered, it cannot merge, and all entries are in use. A store that matches a held entry while the buffer is full is taken without a stall.
- R8: The head entry cannot take merges in a cycle where `dr_ready` is 1. A store to the head's block in that cycle claims a new entry, and the drained head carries only its earlier bytes.
- R9: A store that arrives while a full buffer drains is stalled in that cycle and is taken in the next cycle into the freed entry.
- R10: While `dr_valid` is 1 and `dr_ready` is 0, `dr_valid` stays 1 and `dr_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | A store is offered |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store data word |
| st_be | input | 8 | Byte enables within the word |
| st_stall | output | 1 | The store is not taken this cycle |
| dr_valid | output | 1 | The head entry is presented for drain |
| dr_ready | input | 1 | The second level accepts the head entry |
| dr_addr | output | 32 | Block-aligned address of the head entry |
| dr_data | output | 256 | Block data of the head entry |
| dr_mask | output | 32 | Byte-valid mask of the head entry |
| dr_full | output | 1 | The head entry is a full-block write |

## Verification
Two functions can fall in the same cycle: a drain handshake and an arriving store. The store may target the block being drained, or it may arrive while a full buffer frees its head. The bench provokes both cases by raising `dr_ready` in the same cycle that it offers the store. It then judges the result at the ports. In the first case the drained mask must exclude the new bytes, and the bytes must reappear in a second entry. In the second case the store must stall exactly once and must then drain last.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

  typedef enum logic [1:0] {
    ENT_IDLE  = 2'd0,
    ENT_ALLOC = 2'd1,
    ENT_MERGE = 2'd2,
    ENT_CLEAR = 2'd3
  } ent_op_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/wbm_entry.sv
module wbm_entry
  import wbm_pkg::*;
#(
  parameter int TAG_W      = 27,
  parameter int BLK_BYTES  = 32,
  parameter int WORD_BYTES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ent_op_e                   op,
  input  logic [TAG_W-1:0]          tag_in,
  input  logic [SEL_W-1:0]          word_sel,
  input  logic [WORD_BYTES*8-1:0]   wdata,
  input  logic [WORD_BYTES-1:0]     wbe,
  output logic                      vld,
  output logic [TAG_W-1:0]          tag,
  output logic [BLK_BYTES*8-1:0]    data,
  output logic [BLK_BYTES-1:0]      mask
);
  localparam int WPB   = BLK_BYTES / WORD_BYTES;
  localparam int SEL_W = clog2_min1(WPB);

  logic                   vld_q, vld_d;
  logic [TAG_W-1:0]       tag_q, tag_d;
  logic [BLK_BYTES*8-1:0] data_q, data_d;
  logic [BLK_BYTES-1:0]   mask_q, mask_d;
  logic                   en;

  always_comb begin
    vld_d  = vld_q;
    tag_d  = tag_q;
    data_d = data_q;
    mask_d = mask_q;
    en     = 1'b0;
    case (op)
      ENT_ALLOC: begin vld_d = 1'b1; tag_d = tag_in; mask_d = '0; en = 1'b1; end
      ENT_MERGE: en = 1'b1;
      ENT_CLEAR: begin vld_d = 1'b0; mask_d = '0; en = 1'b1; end
      default:   en = 1'b0;
    endcase
    if (op == ENT_ALLOC || op == ENT_MERGE) begin
      for (int w = 0; w < WPB; w++) begin
        for (int b = 0; b < WORD_BYTES; b++) begin
          if (word_sel == SEL_W'(w) && wbe[b]) begin
            data_d[(w*WORD_BYTES+b)*8 +: 8] = wdata[b*8 +: 8];
            mask_d[w*WORD_BYTES+b]          = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mask_q <= '0;
    end else if (en) begin
      vld_q  <= vld_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      tag_q  <= tag_d;
      data_q <= data_d;
    end
  end

  assign vld  = vld_q;
  assign tag  = tag_q;
  assign data = data_q;
  assign mask = mask_q;

endmodule

// File: rtl/wbm_match.sv
module wbm_match
  import wbm_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int TAG_W   = 27
) (
  input  logic [NUM_ENT-1:0]            vld,
  input  logic [NUM_ENT-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              tag_in,
  input  logic [NUM_ENT-1:0]            excl,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);
  localparam int IDX_W = clog2_min1(NUM_ENT);

  logic [NUM_ENT-1:0] eq;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign eq[i] = vld[i] && !excl[i] && (tags[i] == tag_in);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |eq;

endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
  import wbm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  parameter int BLK_BYTES  = 32,
  parameter int NUM_ENT    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [WORD_BYTES*8-1:0] st_data,
  input  logic [WORD_BYTES-1:0]   st_be,
  output logic                    st_stall,
  output logic                    dr_valid,
  input  logic                    dr_ready,
  output logic [ADDR_W-1:0]       dr_addr,
  output logic [BLK_BYTES*8-1:0]  dr_data,
  output logic [BLK_BYTES-1:0]    dr_mask,
  output logic                    dr_full
);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int WOFF_W = $clog2(WORD_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int SEL_W  = clog2_min1(BLK_BYTES / WORD_BYTES);
  localparam int IDX_W  = clog2_min1(NUM_ENT);
  localparam int CNT_W  = $clog2(NUM_ENT + 1);

  logic [NUM_ENT-1:0]                  ent_vld;
  logic [NUM_ENT-1:0][TAG_W-1:0]       ent_tag;
  logic [NUM_ENT-1:0][BLK_BYTES*8-1:0] ent_data;
  logic [NUM_ENT-1:0][BLK_BYTES-1:0]   ent_mask;
  ent_op_e                             ent_op [NUM_ENT];

  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_en;

  logic [TAG_W-1:0] st_tag;
  logic [SEL_W-1:0] st_sel;
  logic [NUM_ENT-1:0] excl;
  logic             hit, full, dr_fire, accept, do_alloc, do_merge;
  logic [IDX_W-1:0] hit_idx;

  assign st_tag = st_addr[ADDR_W-1:OFF_W];
  assign st_sel = st_addr[OFF_W-1:WOFF_W];

  // Handshake and merge eligibility
  assign dr_valid = ent_vld[head_q];
  assign dr_fire  = dr_valid && dr_ready;
  assign excl     = dr_ready ? (NUM_ENT'(1) << head_q) : '0;
  assign full     = (cnt_q == CNT_W'(NUM_ENT));
  assign st_stall = st_valid && !hit && full;
  assign accept   = st_valid && !st_stall;
  assign do_alloc = accept && !hit;
  assign do_merge = accept && hit;

  wbm_match #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) u_match (
    .vld(ent_vld), .tags(ent_tag), .tag_in(st_tag), .excl(excl),
    .hit(hit), .hit_idx(hit_idx)
  );

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    always_comb begin
      if (do_alloc && tail_q == IDX_W'(i))      ent_op[i] = ENT_ALLOC;
      else if (do_merge && hit_idx == IDX_W'(i)) ent_op[i] = ENT_MERGE;
      else if (dr_fire && head_q == IDX_W'(i))   ent_op[i] = ENT_CLEAR;
      else                                       ent_op[i] = ENT_IDLE;
    end

    wbm_entry #(.TAG_W(TAG_W), .BLK_BYTES(BLK_BYTES), .WORD_BYTES(WORD_BYTES)) u_ent (
      .clk(clk), .rst_n(rst_n), .op(ent_op[i]), .tag_in(st_tag),
      .word_sel(st_sel), .wdata(st_data), .wbe(st_be),
      .vld(ent_vld[i]), .tag(ent_tag[i]), .data(ent_data[i]), .mask(ent_mask[i])
    );
  end

  // Pointer and occupancy next state
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (dr_fire)  head_d = (head_q == IDX_W'(NUM_ENT-1)) ? '0 : head_q + 1'b1;
    if (do_alloc) tail_d = (tail_q == IDX_W'(NUM_ENT-1)) ? '0 : tail_q + 1'b1;
    cnt_d  = cnt_q + CNT_W'(do_alloc) - CNT_W'(dr_fire);
    ptr_en = dr_fire || do_alloc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dr_addr = {ent_tag[head_q], {OFF_W{1'b0}}};
  assign dr_data = ent_data[head_q];
  assign dr_mask = ent_mask[head_q];
  assign dr_full = &dr_mask;

endmodule

// File: rtl/wbm_chk.sv
module wbm_chk #(
  parameter int ADDR_W  = 32,
  parameter int NUM_ENT = 4,
  parameter int CNT_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_stall,
  input logic              dr_valid,
  input logic              dr_ready,
  input logic [ADDR_W-1:0] dr_addr,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              do_alloc
);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NUM_ENT));

  // R7
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> cnt_q == CNT_W'(NUM_ENT));

  // R10
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr)));

  // R5
  drain_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && dr_ready && !do_alloc) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R5
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 |-> !dr_valid);

  // R9
  freed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_stall && dr_valid && dr_ready) |=> !st_stall);

endmodule

bind wbuf_merge wbm_chk #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT), .CNT_W(CNT_W)) u_wbm_chk (
  .clk(clk), .rst_n(rst_n), .st_stall(st_stall), .dr_valid(dr_valid),
  .dr_ready(dr_ready), .dr_addr(dr_addr), .cnt_q(cnt_q), .do_alloc(do_alloc)
);

// File: tb/test_wbuf_merge.sv
module test_wbuf_merge;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid;
  logic [31:0]  st_addr;
  logic [63:0]  st_data;
  logic [7:0]   st_be;
  logic         st_stall;
  logic         dr_valid;
  logic         dr_ready;
  logic [31:0]  dr_addr;
  logic [255:0] dr_data;
  logic [31:0]  dr_mask;
  logic         dr_full;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  wbuf_merge i_wbuf_merge (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_mask(dr_mask), .dr_full(dr_full)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [63:0] d;
    logic [7:0]  be;
    logic        stall;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{32'h0000_0100, 64'h1111_1111_1111_1111, 8'hFF, 1'b0},
    '{32'h0000_0108, 64'h2222_2222_2222_2222, 8'hFF, 1'b0},
    '{32'h0000_0110, 64'h3333_3333_3333_3333, 8'h0F, 1'b0},
    '{32'h0000_0200, 64'h4444_4444_4444_4444, 8'hFF, 1'b0},
    '{32'h0000_0100, 64'hAAAA_BBBB_CCCC_DDDD, 8'hF0, 1'b0},
    '{32'h0000_0300, 64'h0000_0000_0000_0055, 8'h01, 1'b0},
    '{32'h0000_0400, 64'h6600_0000_0000_0000, 8'h80, 1'b0},
    '{32'h0000_0500, 64'h7777_7777_7777_7777, 8'hFF, 1'b1},
    '{32'h0000_0318, 64'h8888_8888_8888_8888, 8'hFF, 1'b0}
  };

  logic [31:0]  m_addr [0:7];
  logic [255:0] m_data [0:7];
  logic [31:0]  m_mask [0:7];
  int           m_cnt = 0;

  function automatic logic [255:0] expand(input logic [31:0] m);
    logic [255:0] r;
    for (int i = 0; i < 32; i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be, input bit skip_head);
    int j;
    j = -1;
    for (int k = (skip_head ? 1 : 0); k < m_cnt; k++)
      if (m_addr[k] == {a[31:5], 5'b0}) j = k;
    if (j < 0) begin
      j = m_cnt;
      m_addr[j] = {a[31:5], 5'b0};
      m_data[j] = '0;
      m_mask[j] = '0;
      m_cnt++;
    end
    for (int b = 0; b < 8; b++) begin
      if (be[b]) begin
        m_data[j][(int'(a[4:3])*8+b)*8 +: 8] = d[b*8 +: 8];
        m_mask[j][int'(a[4:3])*8+b] = 1'b1;
      end
    end
  endtask

  task automatic m_pop();
    for (int k = 0; k < 7; k++) begin
      m_addr[k] = m_addr[k+1];
      m_data[k] = m_data[k+1];
      m_mask[k] = m_mask[k+1];
    end
    m_cnt--;
  endtask

  // Compare presented head with model head; called 1 ns before a rising edge.
  task automatic check_head(input string req);
    chk(dr_valid == 1'b1, {req, " dr_valid"}, 256'(dr_valid), 256'(1));
    chk(dr_addr == m_addr[0], {req, " dr_addr"}, 256'(dr_addr), 256'(m_addr[0]));
    chk(dr_mask == m_mask[0], {req, " dr_mask"}, 256'(dr_mask), 256'(m_mask[0]));
    chk((dr_data & expand(dr_mask)) == (m_data[0] & expand(m_mask[0])), {req, " dr_data"},
        dr_data & expand(dr_mask), m_data[0] & expand(m_mask[0]));
    chk(dr_full == (&m_mask[0]), "R4 dr_full", 256'(dr_full), 256'(&m_mask[0]));
  endtask

  task automatic drive_store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = d;
    st_be    = be;
  endtask

  task automatic drain_all(input string req);
    while (m_cnt > 0) begin
      @(negedge clk);
      st_valid = 1'b0;
      dr_ready = 1'b1;
      #1;
      check_head(req);
      m_pop();
      @(posedge clk);
    end
    @(negedge clk);
    dr_ready = 1'b0;
    #1;
    chk(dr_valid == 1'b0, "R5 empty after drain", 256'(dr_valid), 256'(0));
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held_addr;
    rst_n    = 1'b0;
    st_valid = 1'b1;
    st_addr  = 32'h100;
    st_data  = '0;
    st_be    = 8'hFF;
    dr_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(dr_valid == 1'b0, "R1 dr_valid in reset", 256'(dr_valid), 256'(0));
    chk(st_stall == 1'b0, "R1 st_stall in reset", 256'(st_stall), 256'(0));
    @(negedge clk);
    st_valid = 1'b0;
    rst_n = 1'b1;
    #1;
    chk(dr_valid == 1'b0, "R1 dr_valid after reset", 256'(dr_valid), 256'(0));
    chk(st_stall == 1'b0, "R1 st_stall after reset", 256'(st_stall), 256'(0));

    // Table walk: allocation, merge, overwrite, full-buffer stall and merge (R2 R3 R6 R7)
    for (int v = 0; v < 9; v++) begin
      @(negedge clk);
      drive_store(VEC[v].a, VEC[v].d, VEC[v].be);
      #1;
      chk(st_stall == VEC[v].stall, VEC[v].stall ? "R6 stall on fifth block" : "R7 no stall",
          256'(st_stall), 256'(VEC[v].stall));
      if (!VEC[v].stall) m_store(VEC[v].a, VEC[v].d, VEC[v].be, 1'b0);
      @(posedge clk);
    end

    // R10: head held while not ready
    @(negedge clk);
    st_valid = 1'b0;
    #1;
    held_addr = dr_addr;
    repeat (2) @(posedge clk);
    #1;
    chk(dr_valid == 1'b1 && dr_addr == held_addr, "R10 hold", 256'(dr_addr), 256'(held_addr));

    drain_all("R5 R3 R2 order");

    // R4: four words of one block coalesce to a full-block write
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      drive_store(32'h600 + 32'(w*8), {8{8'(8'hC0 + w)}}, 8'hFF);
      #1;
      m_store(32'h600 + 32'(w*8), {8{8'(8'hC0 + w)}}, 8'hFF, 1'b0);
      @(posedge clk);
    end
    @(negedge clk);
    st_valid = 1'b0;
    #1;
    chk(dr_full == 1'b1, "R4 full block", 256'(dr_full), 256'(1));
    drain_all("R4 drain");

    // R8: store to the head block in the drain cycle goes to a new entry
    @(negedge clk);
    drive_store(32'h700, 64'h0102_0304_0506_0708, 8'hFF);
    #1;
    m_store(32'h700, 64'h0102_0304_0506_0708, 8'hFF, 1'b0);
    @(posedge clk);
    @(negedge clk);
    drive_store(32'h708, 64'h1112_1314_1516_1718, 8'hFF);
    dr_ready = 1'b1;
    #1;
    chk(st_stall == 1'b0, "R8 no stall", 256'(st_stall), 256'(0));
    check_head("R8 head excludes merge");
    m_store(32'h708, 64'h1112_1314_1516_1718, 8'hFF, 1'b1);
    m_pop();
    @(posedge clk);
    chk(m_cnt == 1, "R8 model", 256'(m_cnt), 256'(1));
    drain_all("R8 new entry");

    // R9: store offered while a full buffer drains
    for (int e = 0; e < 4; e++) begin
      @(negedge clk);
      drive_store(32'h800 + 32'(e*32'h100), 64'(e + 1), 8'h01);
      #1;
      m_store(32'h800 + 32'(e*32'h100), 64'(e + 1), 8'h01, 1'b0);
      @(posedge clk);
    end
    @(negedge clk);
    drive_store(32'hC00, 64'h9, 8'h01);
    dr_ready = 1'b1;
    #1;
    chk(st_stall == 1'b1, "R9 stall in drain cycle", 256'(st_stall), 256'(1));
    check_head("R9 head");
    m_pop();
    @(posedge clk);
    @(negedge clk);
    dr_ready = 1'b0;
    #1;
    chk(st_stall == 1'b0, "R9 taken next cycle", 256'(st_stall), 256'(0));
    m_store(32'hC00, 64'h9, 8'h01, 1'b0);
    @(posedge clk);
    drain_all("R9 order");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule